// File: doc/BRIEF.md
# Interrupt and Handshake Control Lines

This unit serves one side of a parallel interface adapter. It watches two peripheral control lines. The first line, C1, is an input only. The second line, C2, can work as an input or as an output. The unit raises two interrupt flags when it sees a programmed edge on either line. It combines those flags into an active-low interrupt request. When C2 is configured as an output, the unit generates a handshake level, a one-cycle strobe pulse or a fixed level. The events that drive these outputs are the processor's accesses to the data register on that side.

A single parameter selects the flavour of the side. A read-triggered side ties its handshake and pulse to data reads, which suits input transfers. A write-triggered side ties them to data writes, which suits output transfers. On both flavours, reading the data register clears both flags.

Register decoding happens outside this unit. The configuration arrives on two small ports, and the data access strobes arrive as single-cycle pulses.

Top module: `ctl_line_unit`

## Requirements
- R1: `c1_cfg[1]` selects which C1 edge is active: 1 for a rising edge, 0 for a falling edge. An active C1 edge sets `flag_c1` whatever the value of `c1_cfg[0]`. An edge of the other polarity leaves `flag_c1` unchanged.
- R2: `c1_cfg[0]`=1 lets `flag_c1` pull `irq_n` low. When `c1_cfg[0]`=0, `flag_c1` has no effect on `irq_n`.
- R3: With `c2_cfg[2]`=0, C2 is an input. `c2_cfg[1]` selects its active edge (1 rising, 0 falling), and an active edge sets `flag_c2`. `c2_cfg[0]`=1 lets `flag_c2` pull `irq_n` low.
- R4: `irq_n` is active low. It is low exactly when at least one flag is set and enabled onto the request.
- R5: A cycle with `data_rd` high clears both flags. If an active edge arrives in that same cycle, the edge wins and its flag ends up set.
- R6: With `c2_cfg[2]`=1, the following hold:
  - `c2_oe` is 1.
  - `flag_c2` is held at 0 and edges on C2 are ignored.
  - `flag_c2` cannot pull `irq_n` low.
- R7: On a read-triggered side, mode `c2_cfg`=100 is the handshake mode. In this mode:
  - `c2_out` goes low on the clock after a `data_rd` cycle.
  - `c2_out` goes high on the clock that registers an active C1 edge.
  - `data_wr` has no effect.
- R8: On a read-triggered side, mode `c2_cfg`=101 is the pulse mode. `c2_out` is low for exactly one cycle after each `data_rd` cycle and high otherwise. `data_wr` has no effect.
- R9: Mode `c2_cfg`=110 drives `c2_out` low and mode `c2_cfg`=111 drives it high, one clock after the mode is applied.
- R10: On a write-triggered side, handshake and pulse modes use `data_wr` in place of `data_rd`:
  - In handshake mode, `data_wr` drives `c2_out` low and an active C1 edge drives it high.
  - In pulse mode, `c2_out` is low for one cycle after each `data_wr`.
  - `data_rd` does not change `c2_out` in either mode.
- R11: The lines pass through a two-stage synchronizer. A line change made before clock edge k sets its flag at edge k+2 and not earlier. After reset, the outputs are: both flags 0, `irq_n` high, `c2_out` high and `c2_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c1_cfg | input | 2 | {C1 rising-edge select, C1 interrupt enable} |
| c2_cfg | input | 3 | {output mode, edge select / output sub-mode, interrupt enable / level} |
| data_rd | input | 1 | One-cycle strobe: processor reads this side's data register |
| data_wr | input | 1 | One-cycle strobe: processor writes this side's data register |
| c1_in | input | 1 | Asynchronous C1 line |
| c2_in | input | 1 | Asynchronous C2 line (used in input mode) |
| flag_c1 | output | 1 | C1 interrupt flag |
| flag_c2 | output | 1 | C2 interrupt flag |
| irq_n | output | 1 | Interrupt request, active low |
| c2_out | output | 1 | C2 value driven in output modes |
| c2_oe | output | 1 | C2 output enable |

## Verification
Each line is driven through both polarities under both edge selections. This separates an active edge from the inactive one and shows whether edge detection is inverted. Reads and edges are applied alone and also in the same cycle, which pins down the clear-versus-set priority. A read-triggered instance and a write-triggered instance receive the same strobe sequences, so the bench can show that each side responds to its own strobe and ignores the other. Line changes are sampled one cycle before and one cycle at the expected flag edge, which shows any missing or extra synchronizer stage.

// File: rtl/ctl_line_pkg.sv
package ctl_line_pkg;

  typedef logic [2:0] c2_mode_t;

  localparam c2_mode_t C2_HANDSHAKE = 3'b100;
  localparam c2_mode_t C2_PULSE     = 3'b101;
  localparam c2_mode_t C2_DRIVE_LO  = 3'b110;
  localparam c2_mode_t C2_DRIVE_HI  = 3'b111;

  // Active edge seen between two successive samples
  function automatic logic edge_hit(input logic prev, input logic cur, input logic rise_sel);
    return rise_sel ? (cur & ~prev) : (prev & ~cur);
  endfunction

  // Interrupt flag update: set wins over clear, hold_zero overrides all
  function automatic logic flag_next(input logic cur, input logic set, input logic clr,
                                     input logic hold_zero);
    if (hold_zero) return 1'b0;
    if (set)       return 1'b1;
    if (clr)       return 1'b0;
    return cur;
  endfunction

  // Next level of the C2 output register
  function automatic logic c2_next(input c2_mode_t mode, input logic cur,
                                   input logic c1_evt, input logic strobe);
    case (mode)
      C2_HANDSHAKE: return c1_evt ? 1'b1 : (strobe ? 1'b0 : cur);
      C2_PULSE:     return ~strobe;
      C2_DRIVE_LO:  return 1'b0;
      C2_DRIVE_HI:  return 1'b1;
      default:      return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl_line_edge.sv
module ctl_line_edge
  import ctl_line_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] rise_sel,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= cur;

  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    assign hit[i] = edge_hit(prev[i], cur[i], rise_sel[i]);
  end
endmodule

// File: rtl/ctl_line_flags.sv
module ctl_line_flags
  import ctl_line_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic c1_evt,
  input  logic c2_evt,
  input  logic clr,
  input  logic c2_is_out,
  input  logic c1_en,
  input  logic c2_en,
  output logic flag_c1,
  output logic flag_c2,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_c1 <= 1'b0;
      flag_c2 <= 1'b0;
    end else begin
      flag_c1 <= flag_next(flag_c1, c1_evt, clr, 1'b0);
      flag_c2 <= flag_next(flag_c2, c2_evt, clr, c2_is_out);
    end

  logic req_c1, req_c2;
  assign req_c1 = flag_c1 & c1_en;
  assign req_c2 = flag_c2 & c2_en & ~c2_is_out;
  assign irq_n  = ~(req_c1 | req_c2);
endmodule

// File: rtl/ctl_line_c2drv.sv
module ctl_line_c2drv
  import ctl_line_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  c2_mode_t mode,
  input  logic     c1_evt,
  input  logic     strobe,
  output logic     c2_out,
  output logic     c2_oe
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) c2_out <= 1'b1;
    else        c2_out <= c2_next(mode, c2_out, c1_evt, strobe);

  assign c2_oe = mode[2];
endmodule

// File: rtl/ctl_line_unit.sv
module ctl_line_unit
  import ctl_line_pkg::*;
#(
  parameter bit TRIG_ON_WRITE = 1'b0,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] c1_cfg,
  input  logic [2:0] c2_cfg,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic       c1_in,
  input  logic       c2_in,
  output logic       flag_c1,
  output logic       flag_c2,
  output logic       irq_n,
  output logic       c2_out,
  output logic       c2_oe
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s, hit;
  logic c1_evt, c2_evt, strobe, c2_is_out;

  ctl_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({c2_in, c1_in}), .q(line_s)
  );

  ctl_line_edge #(.WIDTH(LINES)) edge_i (
    .clk(clk), .rst_n(rst_n), .cur(line_s),
    .rise_sel({c2_cfg[1], c1_cfg[1]}), .hit(hit)
  );

  assign c2_is_out = c2_cfg[2];
  assign c1_evt    = hit[0];
  assign c2_evt    = hit[1] & ~c2_is_out;
  assign strobe    = TRIG_ON_WRITE ? data_wr : data_rd;

  ctl_line_flags flags_i (
    .clk(clk), .rst_n(rst_n), .c1_evt(c1_evt), .c2_evt(c2_evt), .clr(data_rd),
    .c2_is_out(c2_is_out), .c1_en(c1_cfg[0]), .c2_en(c2_cfg[0]),
    .flag_c1(flag_c1), .flag_c2(flag_c2), .irq_n(irq_n)
  );

  ctl_line_c2drv c2drv_i (
    .clk(clk), .rst_n(rst_n), .mode(c2_cfg), .c1_evt(c1_evt), .strobe(strobe),
    .c2_out(c2_out), .c2_oe(c2_oe)
  );
endmodule

// File: rtl/ctl_line_unit_chk.sv
module ctl_line_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       c1_en,
  input logic [2:0] c2_cfg,
  input logic       data_rd,
  input logic       strobe,
  input logic       c1_evt,
  input logic       c2_evt,
  input logic       flag_c1,
  input logic       flag_c2,
  input logic       irq_n,
  input logic       c2_out
);
  AST_C1_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    c1_evt |=> flag_c1); // R1
  AST_C1_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1_en && (!c2_cfg[0] || c2_cfg[2])) |-> irq_n); // R2
  AST_C2_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    c2_evt |=> flag_c2); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_c1 || flag_c2)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !c1_evt) |=> !flag_c1); // R5
  AST_OUT_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    c2_cfg[2] |=> !flag_c2); // R6
  AST_HANDSHAKE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_cfg == 3'b100 && c1_evt) |=> c2_out); // R7
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_cfg == 3'b101 && strobe) |=> !c2_out); // R8
  AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_cfg == 3'b111) |=> c2_out); // R9
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (c2_cfg == 3'b110) |=> !c2_out); // R9
endmodule

bind ctl_line_unit ctl_line_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .c1_en(c1_cfg[0]), .c2_cfg(c2_cfg), .data_rd(data_rd),
  .strobe(strobe), .c1_evt(c1_evt), .c2_evt(c2_evt), .flag_c1(flag_c1),
  .flag_c2(flag_c2), .irq_n(irq_n), .c2_out(c2_out)
);

// File: tb/ctl_line_unit_tb_top.sv
module ctl_line_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] a_c1_cfg = '0, b_c1_cfg = '0;
  logic [2:0] a_c2_cfg = '0, b_c2_cfg = '0;
  logic data_rd = 1'b0, data_wr = 1'b0, c1_in = 1'b0, c2_in = 1'b0;
  logic a_f1, a_f2, a_irq_n, a_c2, a_oe;
  logic b_f1, b_f2, b_irq_n, b_c2, b_oe;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_line_unit #(.TRIG_ON_WRITE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .c1_cfg(a_c1_cfg), .c2_cfg(a_c2_cfg),
    .data_rd(data_rd), .data_wr(data_wr), .c1_in(c1_in), .c2_in(c2_in),
    .flag_c1(a_f1), .flag_c2(a_f2), .irq_n(a_irq_n), .c2_out(a_c2), .c2_oe(a_oe)
  );

  ctl_line_unit #(.TRIG_ON_WRITE(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .c1_cfg(b_c1_cfg), .c2_cfg(b_c2_cfg),
    .data_rd(data_rd), .data_wr(data_wr), .c1_in(c1_in), .c2_in(c2_in),
    .flag_c1(b_f1), .flag_c2(b_f2), .irq_n(b_irq_n), .c2_out(b_c2), .c2_oe(b_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd_strobe();
    data_rd = 1'b1; tick(); data_rd = 1'b0;
  endtask

  task automatic wr_strobe();
    data_wr = 1'b1; tick(); data_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 flag_c1 reset", a_f1, 1'b0);
    chk("R11 flag_c2 reset", a_f2, 1'b0);
    chk("R11 irq_n reset", a_irq_n, 1'b1);
    chk("R11 c2_out reset", a_c2, 1'b1);
    chk("R11 c2_oe reset", a_oe, 1'b0);
    chk("R11 side B c2_out reset", b_c2, 1'b1);
  endtask

  task automatic t_c1_edges();
    a_c1_cfg = 2'b00;
    c1_in = 1'b1; tick(3);
    chk("R1 rising ignored when falling selected", a_f1, 1'b0);
    c1_in = 1'b0; tick(2);
    chk("R11 no flag before sync latency", a_f1, 1'b0);
    tick();
    chk("R1 falling edge sets flag", a_f1, 1'b1);
    chk("R2 disabled flag leaves irq_n high", a_irq_n, 1'b1);
    a_c1_cfg = 2'b01; #1;
    chk("R2 enabled flag pulls irq_n low", a_irq_n, 1'b0);
    rd_strobe();
    chk("R5 read clears flag_c1", a_f1, 1'b0);
    chk("R4 irq_n released after clear", a_irq_n, 1'b1);
    a_c1_cfg = 2'b11;
    c1_in = 1'b1; tick(3);
    chk("R1 rising edge sets flag", a_f1, 1'b1);
    chk("R4 irq_n low with enabled flag", a_irq_n, 1'b0);
    rd_strobe();
  endtask

  task automatic t_c2_input();
    a_c2_cfg = 3'b001;
    c2_in = 1'b1; tick(3);
    chk("R3 rising ignored when falling selected", a_f2, 1'b0);
    c2_in = 1'b0; tick(3);
    chk("R3 falling edge sets flag_c2", a_f2, 1'b1);
    chk("R3 enabled flag_c2 pulls irq_n low", a_irq_n, 1'b0);
    rd_strobe();
    chk("R5 read clears flag_c2", a_f2, 1'b0);
    a_c2_cfg = 3'b011;
    c2_in = 1'b1; tick(3);
    chk("R3 rising edge sets flag_c2", a_f2, 1'b1);
    rd_strobe();
    a_c2_cfg = 3'b010;
    c2_in = 1'b0; tick(3);
    chk("R3 falling ignored when rising selected", a_f2, 1'b0);
    c2_in = 1'b1; tick(3);
    chk("R3 flag_c2 set with enable off", a_f2, 1'b1);
    chk("R3 disabled flag_c2 leaves irq_n high", a_irq_n, 1'b1);
    rd_strobe();
  endtask

  task automatic t_coincident();
    a_c1_cfg = 2'b10;
    c1_in = 1'b0; tick(3);
    c1_in = 1'b1; tick(2);
    data_rd = 1'b1; tick(); data_rd = 1'b0;
    chk("R5 edge wins over same-cycle read", a_f1, 1'b1);
    rd_strobe();
    chk("R5 later read clears flag", a_f1, 1'b0);
  endtask

  task automatic t_out_modes();
    a_c2_cfg = 3'b110; tick();
    chk("R6 output enable in output mode", a_oe, 1'b1);
    chk("R9 manual low", a_c2, 1'b0);
    c2_in = 1'b0; tick(3);
    c2_in = 1'b1; tick(3);
    chk("R6 flag_c2 held at 0 in output mode", a_f2, 1'b0);
    a_c2_cfg = 3'b111; tick();
    chk("R9 manual high", a_c2, 1'b1);
    chk("R6 no request from C2 in output mode", a_irq_n, 1'b1);
  endtask

  task automatic t_handshake_a();
    a_c2_cfg = 3'b100; a_c1_cfg = 2'b10;
    c1_in = 1'b0; tick(3);
    rd_strobe();
    chk("R7 read drives C2 low", a_c2, 1'b0);
    c1_in = 1'b1; tick(2);
    chk("R7 C2 still low before edge registers", a_c2, 1'b0);
    tick();
    chk("R7 C1 edge drives C2 high", a_c2, 1'b1);
    wr_strobe();
    chk("R7 write ignored on read side", a_c2, 1'b1);
    rd_strobe();
    chk("R7 second read drives C2 low", a_c2, 1'b0);
  endtask

  task automatic t_pulse_a();
    a_c2_cfg = 3'b101; tick();
    chk("R8 idle high", a_c2, 1'b1);
    rd_strobe();
    chk("R8 low after read", a_c2, 1'b0);
    tick();
    chk("R8 pulse lasts one cycle", a_c2, 1'b1);
    wr_strobe();
    chk("R8 write ignored on read side", a_c2, 1'b1);
  endtask

  task automatic t_side_b();
    b_c1_cfg = 2'b10; b_c2_cfg = 3'b100; tick();
    c1_in = 1'b0; tick(3);
    wr_strobe();
    chk("R10 write drives C2 low", b_c2, 1'b0);
    rd_strobe();
    chk("R10 read ignored by C2", b_c2, 1'b0);
    c1_in = 1'b1; tick(3);
    chk("R10 C1 edge drives C2 high", b_c2, 1'b1);
    b_c2_cfg = 3'b101; tick();
    wr_strobe();
    chk("R10 pulse low after write", b_c2, 1'b0);
    tick();
    chk("R10 pulse lasts one cycle", b_c2, 1'b1);
    rd_strobe();
    chk("R10 read gives no pulse", b_c2, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_c1_edges();
    t_c2_input();
    t_coincident();
    t_out_modes();
    t_handshake_a();
    t_pulse_a();
    t_side_b();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule